// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block decodes the command writes a host sends to a parallel NOR flash and keeps the three pieces of state that decide how the device behaves: the active command byte, a write-cycle counter and an 8-bit status register. Reads are steered from that state. In read-array mode they return the contents of a small internal byte array. In the operation and status modes they return the status register. In query mode they return a fixed identification table.

Program and erase operations change the internal array. Each one then holds the block busy for a fixed `OP_CYCLES` clocks before reporting ready. The host talks to the block over a plain synchronous bus with a write strobe, a read strobe, an address and 8-bit data. The current command, cycle counter, status and read source are also brought out as ports so that the surrounding logic can observe the mode.

Several paths lead back to read-array mode: explicit commands, error conditions and abandoned sequences. They all share one exit. That exit sets the command to 0xFF and the cycle counter to 0, and it never clears status error bits.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the command is 0xFF, the write-cycle counter is 0, the status is 0x00, the read source is the array (code 0), and every array byte is 0xFF.
- R2: A first-cycle write of 0xFF or 0xF0 returns the block to read-array mode: command 0xFF, counter 0, source code 0. The status is left unchanged.
- R3: A first-cycle write of 0x50 sets the status to 0x00 and enters read-array mode.
- R4: A first-cycle write of 0x60 sets the counter to 1. A second write of 0x01 or 0xD0 completes the sequence: counter 0, command stays 0x60, status bit 7 set, source code 1 (status). A second write of 0xFF or of any other value returns to read-array mode.
- R5: A first-cycle write of 0x98 enters query mode (command 0x98, counter 1, source code 2). Reads there return 0x51, 0x52 and 0x59 at addresses 0x10, 0x11 and 0x12. A later write of 0xFF returns to read-array mode, and any other write keeps query mode.
- R6: A first-cycle write of 0x40 or 0x10, followed by a data write, stores that byte at the write address. It clears status bit 7 and holds the counter at 2 for exactly OP_CYCLES clocks. The counter then goes to 0 and bit 7 is set. Writes made while the counter is 2 are ignored.
- R7: A first-cycle write of 0x20 followed by 0xD0 sets every array byte to 0xFF, with the same busy and ready timing as R6. A second write of 0xFF returns to read-array mode. Any other second value sets status bits 5 and 4 (mask 0x30) and returns to read-array mode.
- R8: An unrecognised first-cycle command returns to read-array mode and leaves the status unchanged.
- R9: Status error bits 5:4 are cleared only by reset or by a 0x50 command. No return to read-array mode clears them.
- R10: A first-cycle write of 0x70 sets the command to 0x70 with counter 0, and reads come from the status register (source code 1).
- R11: Read data is registered. The clock edge that samples the read strobe loads rdata from the source selected at that edge. Array bytes are read at the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data or command byte |
| wr_en | input | 1 | Write strobe, one write per clock |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| cmd_o | output | 8 | Active command byte |
| wcycle_o | output | 2 | Write-cycle counter (0 idle, 1 awaiting second write, 2 busy) |
| status_o | output | 8 | Status register |
| rd_src_o | output | 2 | Read source: 0 array, 1 status, 2 query |

## Verification
The bench targets the shared exit to read-array mode. It first raises error bits with a bad erase confirm, then passes through 0xFF, 0xF0 and an unknown command. A design that wiped the status on that exit would lose 0x30, and only the 0x50 command may clear it. The bench also writes a read-array byte while the block is busy. A design that decoded that write would end with command 0xFF instead of 0x40. The bench times the busy window to the clock, which catches an off-by-one in ready reporting. In query mode it sends a non-0xFF write; a design that treated it as an exit would start returning array bytes in place of the identification table.

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int ADDR_W    = 6,
  parameter int OP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic [7:0]        cmd_o,
  output logic [1:0]        wcycle_o,
  output logic [7:0]        status_o,
  output logic [1:0]        rd_src_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(OP_CYCLES + 1);

  logic [7:0]    mem [DEPTH];
  logic [7:0]    cmd, cmd_n, stat, stat_n;
  logic [1:0]    wc, wc_n;
  logic [CW-1:0] cnt;
  logic          to_ra, start, prog, erase;
  logic [7:0]    qry;

  always_comb begin
    cmd_n = cmd; wc_n = wc; stat_n = stat;
    to_ra = 1'b0; start = 1'b0; prog = 1'b0; erase = 1'b0;
    if (wc == 2'd2) begin
      if (cnt == '0) begin
        wc_n = 2'd0;
        stat_n = stat | 8'h80;
      end
    end else if (wr_en) begin
      case (wc)
        2'd0:
          case (wdata)
            8'hFF, 8'hF0: to_ra = 1'b1;
            8'h50: begin stat_n = 8'h00; to_ra = 1'b1; end
            8'h70: cmd_n = 8'h70;
            8'h60, 8'h20, 8'h40, 8'h10, 8'h98: begin cmd_n = wdata; wc_n = 2'd1; end
            default: to_ra = 1'b1;
          endcase
        2'd1:
          case (cmd)
            8'h40, 8'h10: begin prog = 1'b1; start = 1'b1; end
            8'h20:
              if (wdata == 8'hD0) begin erase = 1'b1; start = 1'b1; end
              else if (wdata == 8'hFF) to_ra = 1'b1;
              else begin stat_n = stat | 8'h30; to_ra = 1'b1; end
            8'h60:
              if (wdata == 8'h01 || wdata == 8'hD0) begin
                wc_n = 2'd0;
                stat_n = stat | 8'h80;
              end else to_ra = 1'b1;
            8'h98: if (wdata == 8'hFF) to_ra = 1'b1;
            default: to_ra = 1'b1;
          endcase
        default: to_ra = 1'b1;
      endcase
    end
    if (start) begin
      wc_n = 2'd2;
      stat_n = stat_n & 8'h7F;
    end
    if (to_ra) begin
      cmd_n = 8'hFF;
      wc_n = 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd  <= 8'hFF;
      wc   <= 2'd0;
      stat <= 8'h00;
      cnt  <= '0;
    end else begin
      cmd  <= cmd_n;
      wc   <= wc_n;
      stat <= stat_n;
      if (start) cnt <= CW'(OP_CYCLES - 1);
      else if (wc == 2'd2 && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog) begin
      mem[addr] <= wdata;
    end
  end

  always_comb begin
    if (addr == ADDR_W'(16))      qry = 8'h51;
    else if (addr == ADDR_W'(17)) qry = 8'h52;
    else if (addr == ADDR_W'(18)) qry = 8'h59;
    else                          qry = 8'h00;
  end

  assign rd_src_o = (cmd == 8'h98) ? 2'd2 :
                    (cmd == 8'hFF && wc == 2'd0) ? 2'd0 : 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= 8'h00;
    else if (rd_en)
      rdata <= (rd_src_o == 2'd0) ? mem[addr] :
               (rd_src_o == 2'd2) ? qry : stat;
  end

  assign cmd_o    = cmd;
  assign wcycle_o = wc;
  assign status_o = stat;
endmodule

module nor_cmd_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic [7:0]        cmd_o,
  input logic [1:0]        wcycle_o,
  input logic [7:0]        status_o,
  input logic [1:0]        rd_src_o
);
  p_ff_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == 8'hFF && wcycle_o != 2'd2 &&
     !(wcycle_o == 2'd1 && (cmd_o == 8'h40 || cmd_o == 8'h10)))
    |=> (cmd_o == 8'hFF && wcycle_o == 2'd0 && rd_src_o == 2'd0));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wcycle_o == 2'd0 && wdata == 8'h50) |=> (status_o == 8'h00));

  p_query_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_src_o == 2'd2 && addr == ADDR_W'(16)) |=> (rdata == 8'h51));

  p_busy_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wcycle_o == 2'd2) |-> !status_o[7]);

  p_done_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wcycle_o) == 2'd2 && wcycle_o == 2'd0) |-> status_o[7]);

  p_err_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wcycle_o == 2'd0 && wdata == 8'h50)
    |=> ((($past(status_o) & ~status_o) & 8'h30) == 8'h00));
endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .cmd_o(cmd_o), .wcycle_o(wcycle_o),
  .status_o(status_o), .rd_src_o(rd_src_o));

// File: tb/nor_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module nor_cmd_ctrl_bench;
  localparam int AW = 6;
  localparam int OPC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata, cmd_o, status_o;
  logic [1:0] wcycle_o, rd_src_o;
  int checks = 0, errors = 0;
  logic [7:0] exp_st = 8'h00;

  always #2.5 clk = ~clk;

  nor_cmd_ctrl #(.ADDR_W(AW), .OP_CYCLES(OPC)) u_nor_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .cmd_o(cmd_o), .wcycle_o(wcycle_o),
    .status_o(status_o), .rd_src_o(rd_src_o));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a[AW-1:0]; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a[AW-1:0]; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic state(string req, logic [7:0] c, logic [1:0] w, logic [1:0] s);
    check({req, " cmd"}, cmd_o, c);
    check({req, " wcycle"}, wcycle_o, w);
    check({req, " status"}, status_o, exp_st);
    check({req, " source"}, rd_src_o, s);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    state("R1 reset", 8'hFF, 2'd0, 2'd0);
    rd(8'h07, d); check("R1/R11 erased byte", d, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] d;
    wr(8'h05, 8'h40); check("R6 setup wcycle", wcycle_o, 2'd1);
    wr(8'h05, 8'h3C);
    check("R6 busy wcycle", wcycle_o, 2'd2);
    check("R6 busy not ready", status_o[7], 1'b0);
    wr(8'h00, 8'hFF);
    repeat (OPC - 2) @(negedge clk);
    exp_st = 8'h80;
    state("R6 done, busy write ignored", 8'h40, 2'd0, 2'd1);
    wr(8'h00, 8'hFF);
    rd(8'h05, d); check("R6/R11 programmed byte", d, 8'h3C);
    wr(8'h06, 8'h10); wr(8'h06, 8'h5A);
    repeat (OPC) @(negedge clk);
    check("R6 alt program done", wcycle_o, 2'd0);
    wr(8'h00, 8'hF0);
    rd(8'h06, d); check("R6 alt programmed byte", d, 8'h5A);
  endtask

  task automatic t_errors();
    wr(8'h00, 8'h20); wr(8'h00, 8'h77);
    exp_st = 8'hB0;
    state("R7 bad confirm", 8'hFF, 2'd0, 2'd0);
    wr(8'h00, 8'hFF); state("R2/R9 FF keeps errors", 8'hFF, 2'd0, 2'd0);
    wr(8'h00, 8'hF0); state("R2/R9 F0 keeps errors", 8'hFF, 2'd0, 2'd0);
    wr(8'h00, 8'h33); state("R8 unknown command", 8'hFF, 2'd0, 2'd0);
    wr(8'h00, 8'h20); wr(8'h00, 8'hFF);
    state("R7 confirm FF exits", 8'hFF, 2'd0, 2'd0);
    wr(8'h00, 8'h50); exp_st = 8'h00;
    state("R3 clear status", 8'hFF, 2'd0, 2'd0);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    wr(8'h00, 8'h60); check("R4 setup wcycle", wcycle_o, 2'd1);
    wr(8'h00, 8'h01); exp_st = 8'h80;
    state("R4 lock done", 8'h60, 2'd0, 2'd1);
    rd(8'h00, d); check("R4/R11 status read", d, 8'h80);
    wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
    state("R4 unlock done", 8'h60, 2'd0, 2'd1);
    wr(8'h00, 8'h60); wr(8'h00, 8'hFF);
    state("R4 FF exit", 8'hFF, 2'd0, 2'd0);
    wr(8'h00, 8'h60); wr(8'h00, 8'h42);
    state("R4 unknown exit", 8'hFF, 2'd0, 2'd0);
  endtask

  task automatic t_query();
    logic [7:0] d;
    wr(8'h00, 8'h98); state("R5 enter", 8'h98, 2'd1, 2'd2);
    rd(8'h10, d); check("R5 Q", d, 8'h51);
    rd(8'h11, d); check("R5 R", d, 8'h52);
    rd(8'h12, d); check("R5 Y", d, 8'h59);
    wr(8'h00, 8'h00); state("R5 other write stays", 8'h98, 2'd1, 2'd2);
    rd(8'h10, d); check("R5 still query", d, 8'h51);
    wr(8'h00, 8'hFF); state("R5 FF exit", 8'hFF, 2'd0, 2'd0);
  endtask

  task automatic t_status_mode();
    logic [7:0] d;
    wr(8'h00, 8'h70); state("R10 read status mode", 8'h70, 2'd0, 2'd1);
    rd(8'h05, d); check("R10 status read", d, 8'h80);
    wr(8'h00, 8'hFF);
  endtask

  task automatic t_erase();
    logic [7:0] d;
    wr(8'h00, 8'h20); wr(8'h00, 8'hD0);
    check("R7 erase busy", wcycle_o, 2'd2);
    check("R7 erase not ready", status_o[7], 1'b0);
    repeat (OPC - 1) @(negedge clk);
    check("R7 still busy at last cycle", wcycle_o, 2'd2);
    @(negedge clk);
    state("R7 erase done", 8'h20, 2'd0, 2'd1);
    wr(8'h00, 8'hFF);
    rd(8'h05, d); check("R7 erased byte 5", d, 8'hFF);
    rd(8'h06, d); check("R7 erased byte 6", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_errors();
    t_lock();
    t_query();
    t_status_mode();
    t_erase();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule